// File: doc/BRIEF.md
# Byte-Wide Access Bridge for 16-bit Registers

This block sits between an 8-bit processor data bus and a small group of 16-bit registers: a free-running counter, a capture register and two compare registers. Each register is reached through a pair of byte addresses. The bridge turns two byte transfers into one atomic 16-bit transfer, so that software never sees a value torn between two updates of the counter.

A single 8-bit holding latch is shared by every register. A high-byte write only parks its byte in the latch. The later low-byte write then emits a one-cycle commit strobe to the target register, with the full 16-bit word built from the latch and the low byte. For reads the order is reversed. A low-byte read of the counter or the capture register returns the live low byte and, on the same edge, freezes the live high byte in the latch. The following high-byte read returns that frozen byte. Compare registers are never changed by the hardware, so reads of them skip the latch entirely. Because the latch is shared, an access to a different register between the two halves of a transfer overwrites it. That behaviour is part of the contract and is not guarded against.

Top module: `wide_reg_bridge`

## Requirements
- R1: Address bit 0 selects the byte (1 = high, 0 = low). Address bits [2:1] select the register: 0 = counter, 1 = capture, 2 = compare A, 3 = compare B. Read data appears on `rd_data` in the cycle after the edge that samples `bus_rd`, and it holds its value until the next accepted read.
- R2: A high-byte write loads `bus_wdata` into the holding latch and produces no commit strobe.
- R3: A low-byte write raises exactly one bit of `commit_stb` (bit = register index) for one cycle, with `commit_data` = {latch, `bus_wdata`}. At all other times `commit_stb` is zero.
- R4: A low-byte read of the counter or the capture register returns the live low byte and loads the live high byte into the latch on the same edge.
- R5: A high-byte read of the counter or the capture register returns the latch contents, not the live high byte.
- R6: Reads of either compare register return the live byte for both halves and leave the latch unchanged.
- R7: The latch is shared. A high-byte write or a latching read to any register replaces the value left by an earlier access to another register.
- R8: A synchronous reset clears the latch, `rd_data`, `commit_stb` and `commit_data` to zero.
- R9: When `bus_wr` and `bus_rd` are both high, only the write is performed. The read changes neither `rd_data` nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte address: register index in [2:1], high-byte select in [0] |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one transfer per cycle it is high |
| bus_rd | input | 1 | Read strobe, one transfer per cycle it is high |
| live_regs | input | 64 | Current 16-bit register values, register i at bits [16i+15:16i] |
| rd_data | output | 8 | Registered read data |
| commit_stb | output | 4 | One-hot 16-bit write commit, bit i targets register i |
| commit_data | output | 16 | 16-bit word committed with `commit_stb` |

## Verification
Every result is due exactly one clock edge after the strobe that causes it. Read data, commit strobes and the latch all update on the edge that samples the request, and `commit_stb` falls again on the following edge. The bench applies each request just after a falling edge, holds it over one rising edge, drops it at the next falling edge and samples the outputs at that same instant. The commit pulse is therefore seen in the only cycle it is high. The latch has no port of its own. The bench observes it only through later high-byte reads and commit words, and it changes the live register values between the two halves of a read to show which byte came from the latch.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  // Kind of bus transfer seen in one cycle
  typedef enum logic [2:0] {
    ACC_IDLE  = 3'd0,
    ACC_WR_HI = 3'd1,
    ACC_WR_LO = 3'd2,
    ACC_RD_HI = 3'd3,
    ACC_RD_LO = 3'd4
  } acc_e;
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
  import wrb_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output acc_e              kind,
  output logic [IDX_W-1:0]  idx
);
  assign idx = addr[ADDR_W-1:1];

  // A write takes precedence over a read in the same cycle
  always_comb begin
    if (wr)      kind = addr[0] ? ACC_WR_HI : ACC_WR_LO;
    else if (rd) kind = addr[0] ? ACC_RD_HI : ACC_RD_LO;
    else         kind = ACC_IDLE;
  end
endmodule

// File: rtl/wrb_temp.sv
module wrb_temp
  import wrb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_e              kind,
  input  logic              bypass,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] live_hi,
  output logic [DATA_W-1:0] temp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q <= '0;
    end else begin
      case (kind)
        ACC_WR_HI: temp_q <= wdata;
        ACC_RD_LO: if (!bypass) temp_q <= live_hi;
        default:   temp_q <= temp_q;
      endcase
    end
  end
endmodule

// File: rtl/wrb_rdpath.sv
module wrb_rdpath
  import wrb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_e              kind,
  input  logic              bypass,
  input  logic [REG_W-1:0]  live_sel,
  input  logic [DATA_W-1:0] temp_q,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (kind)
        ACC_RD_LO: rd_data <= live_sel[DATA_W-1:0];
        ACC_RD_HI: rd_data <= bypass ? live_sel[REG_W-1:DATA_W] : temp_q;
        default:   rd_data <= rd_data;
      endcase
    end
  end
endmodule

// File: rtl/wrb_commit.sv
module wrb_commit
  import wrb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int REG_W = 2 * DATA_W,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  acc_e                kind,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DATA_W-1:0]   temp_q,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_REGS-1:0] commit_stb,
  output logic [REG_W-1:0]    commit_data
);
  always_ff @(posedge clk) begin
    if (rst)                    commit_data <= '0;
    else if (kind == ACC_WR_LO) commit_data <= {temp_q, wdata};
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
    always_ff @(posedge clk) begin
      if (rst) commit_stb[g] <= 1'b0;
      else     commit_stb[g] <= (kind == ACC_WR_LO) && (idx == IDX_W'(g));
    end
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                NUM_REGS    = 4,
  parameter logic [NUM_REGS-1:0] BYPASS_MASK = 4'b1100,
  localparam int REG_W  = 2 * DATA_W,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [NUM_REGS*REG_W-1:0] live_regs,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_REGS-1:0]       commit_stb,
  output logic [REG_W-1:0]          commit_data
);
  acc_e              kind;
  logic [IDX_W-1:0]  idx;
  logic [REG_W-1:0]  live_arr [NUM_REGS];
  logic [REG_W-1:0]  live_sel;
  logic              bypass;
  logic [DATA_W-1:0] temp_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign live_arr[g] = live_regs[g*REG_W +: REG_W];
  end

  assign live_sel = live_arr[idx];
  assign bypass   = BYPASS_MASK[idx];

  wrb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .kind (kind),
    .idx  (idx)
  );

  wrb_temp #(.DATA_W(DATA_W)) u_temp (
    .clk     (clk),
    .rst     (rst),
    .kind    (kind),
    .bypass  (bypass),
    .wdata   (bus_wdata),
    .live_hi (live_sel[REG_W-1:DATA_W]),
    .temp_q  (temp_q)
  );

  wrb_rdpath #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .bypass   (bypass),
    .live_sel (live_sel),
    .temp_q   (temp_q),
    .rd_data  (rd_data)
  );

  wrb_commit #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_cmt (
    .clk         (clk),
    .rst         (rst),
    .kind        (kind),
    .idx         (idx),
    .temp_q      (temp_q),
    .wdata       (bus_wdata),
    .commit_stb  (commit_stb),
    .commit_data (commit_data)
  );
endmodule

// File: rtl/wrb_chk.sv
module wrb_chk #(
  parameter int                  DATA_W      = 8,
  parameter int                  NUM_REGS    = 4,
  parameter logic [NUM_REGS-1:0] BYPASS_MASK = 4'b1100,
  localparam int REG_W  = 2 * DATA_W,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int ADDR_W = IDX_W + 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [NUM_REGS*REG_W-1:0] live_regs,
  input logic [DATA_W-1:0]         rd_data,
  input logic [NUM_REGS-1:0]       commit_stb,
  input logic [REG_W-1:0]          commit_data,
  input logic [DATA_W-1:0]         temp_q
);
  logic [IDX_W-1:0]    c_idx;
  logic [REG_W-1:0]    c_live;
  logic [NUM_REGS-1:0] c_onehot;
  logic                c_byp, c_hi, c_rd_only;

  assign c_idx     = bus_addr[ADDR_W-1:1];
  assign c_hi      = bus_addr[0];
  assign c_live    = live_regs[c_idx*REG_W +: REG_W];
  assign c_byp     = BYPASS_MASK[c_idx];
  assign c_rd_only = bus_rd && !bus_wr;

  always_comb begin
    c_onehot = '0;
    c_onehot[c_idx] = 1'b1;
  end

  // R2
  hi_write_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && c_hi) |=> (temp_q == $past(bus_wdata)) && (commit_stb == '0));

  // R3
  lo_write_word_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !c_hi) |=> (commit_data == {$past(temp_q), $past(bus_wdata)})
                          && (commit_stb == $past(c_onehot)));

  // R3
  commit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(commit_stb));

  // R4
  lo_read_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (c_rd_only && !c_hi && !c_byp) |=>
      (temp_q == $past(c_live[REG_W-1:DATA_W])) && (rd_data == $past(c_live[DATA_W-1:0])));

  // R5
  hi_read_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (c_rd_only && c_hi && !c_byp) |=> rd_data == $past(temp_q));

  // R6
  bypass_read_chk: assert property (@(posedge clk) disable iff (rst)
    (c_rd_only && c_byp) |=> $stable(temp_q));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (temp_q == '0) && (commit_stb == '0) && (rd_data == '0) && (commit_data == '0));

  // R9
  wr_beats_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_rd) |=> $stable(rd_data));
endmodule

bind wide_reg_bridge wrb_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BYPASS_MASK(BYPASS_MASK)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .live_regs(live_regs), .rd_data(rd_data),
  .commit_stb(commit_stb), .commit_data(commit_data), .temp_q(temp_q)
);

// File: tb/test_wide_reg_bridge.sv
module test_wide_reg_bridge;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [63:0] live_regs = '0;
  logic [7:0]  rd_data;
  logic [3:0]  commit_stb;
  logic [15:0] commit_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wide_reg_bridge i_wide_reg_bridge (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .live_regs(live_regs), .rd_data(rd_data),
    .commit_stb(commit_stb), .commit_data(commit_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_live(input int i, input logic [15:0] v);
    live_regs[i*16 +: 16] = v;
  endtask

  // One transfer: drive after a falling edge, drop and sample at the next one
  task automatic xfer(input logic wr, input logic rd, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R8 rd_data after reset", 16'(rd_data), 16'h0000);
    chk("R8 commit_stb after reset", 16'(commit_stb), 16'h0000);
    chk("R8 commit_data after reset", commit_data, 16'h0000);
    set_live(0, 16'h9999);
    xfer(1'b0, 1'b1, 3'd1, 8'h00);
    chk("R8 latch cleared (counter high read)", 16'(rd_data), 16'h0000);
  endtask

  task automatic t_write;
    xfer(1'b1, 1'b0, 3'd1, 8'h12);
    chk("R2 no commit on high write", 16'(commit_stb), 16'h0000);
    xfer(1'b1, 1'b0, 3'd0, 8'h34);
    chk("R3 counter commit strobe", 16'(commit_stb), 16'h0001);
    chk("R3 counter commit word", commit_data, 16'h1234);
    @(negedge clk);
    chk("R3 strobe lasts one cycle", 16'(commit_stb), 16'h0000);
    xfer(1'b1, 1'b0, 3'd7, 8'hAB);
    xfer(1'b1, 1'b0, 3'd6, 8'hCD);
    chk("R1 R3 compare B commit strobe", 16'(commit_stb), 16'h0008);
    chk("R3 compare B commit word", commit_data, 16'hABCD);
  endtask

  task automatic t_read_atomic;
    set_live(0, 16'hBEEF);
    xfer(1'b0, 1'b1, 3'd0, 8'h00);
    chk("R4 counter low read", 16'(rd_data), 16'h00EF);
    set_live(0, 16'h0000);
    xfer(1'b0, 1'b1, 3'd1, 8'h00);
    chk("R5 counter high read from latch", 16'(rd_data), 16'h00BE);
  endtask

  task automatic t_compare;
    set_live(2, 16'h5A6B);
    xfer(1'b0, 1'b1, 3'd4, 8'h00);
    chk("R6 compare A low read", 16'(rd_data), 16'h006B);
    xfer(1'b0, 1'b1, 3'd5, 8'h00);
    chk("R6 compare A high read is live", 16'(rd_data), 16'h005A);
    xfer(1'b0, 1'b1, 3'd3, 8'h00);
    chk("R6 latch untouched by compare reads", 16'(rd_data), 16'h00BE);
  endtask

  task automatic t_shared;
    xfer(1'b1, 1'b0, 3'd1, 8'h11);
    set_live(1, 16'h7788);
    xfer(1'b0, 1'b1, 3'd2, 8'h00);
    chk("R1 capture low read", 16'(rd_data), 16'h0088);
    xfer(1'b1, 1'b0, 3'd0, 8'h22);
    chk("R7 interleaved read replaced latch", commit_data, 16'h7722);
    chk("R7 counter strobe", 16'(commit_stb), 16'h0001);
  endtask

  task automatic t_collide;
    set_live(1, 16'h9911);
    xfer(1'b1, 1'b1, 3'd2, 8'h44);
    chk("R9 write performed", commit_data, 16'h7744);
    chk("R9 capture strobe", 16'(commit_stb), 16'h0002);
    chk("R9 rd_data kept", 16'(rd_data), 16'h0088);
    xfer(1'b0, 1'b1, 3'd3, 8'h00);
    chk("R9 latch not loaded by ignored read", 16'(rd_data), 16'h0077);
    repeat (3) @(negedge clk);
    chk("R1 rd_data holds while idle", 16'(rd_data), 16'h0077);
  endtask

  initial begin
    t_reset();
    t_write();
    t_read_atomic();
    t_compare();
    t_shared();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule